// File: doc/BRIEF.md
# Oversampled Serial Receive Recovery

This block turns one asynchronous serial receive line into parallel characters. It runs from the system clock and does its work only on cycles where an external sample-rate enable pulses. A mode input sets how many enable pulses make up one bit time: sixteen in normal mode, eight in double-speed mode. The line first passes through a two-flop synchronizer. The block then looks for a falling edge on an idle line and checks that the start bit is real with a three-sample vote. It realigns its bit-phase counter at every start bit. After that it decides each data bit, the optional parity bit and the first stop bit from the three samples around the middle of that bit.

Each received character is shown on a parallel data output together with a one-cycle valid strobe. A parity error flag and a framing error flag are valid on the same cycle as the strobe. The character length is a parameter from 5 to 8 bits. Parity on/off and odd/even are selected by inputs. Baud generation, buffering and software access belong to the surrounding logic.

Top module: `serial_rx_recover`

## Requirements
- R1: While reset is high and right after it is released, `rx_valid`, `par_err` and `frame_err` are 0 and `rx_data` is all zeros.
- R2: With `dbl_speed`=0 one bit spans 16 enable ticks; with `dbl_speed`=1 it spans 8. The tick that first sees the line low counts as sample 1, and the bit-phase counter runs from 1 up to the bit length and then wraps to 1.
- R3: The start bit is judged from samples 8, 9 and 10 (normal) or 4, 5 and 6 (double speed). If two or more of them are high, no character is produced and the block waits for a new high-to-low edge. If two or more are low, the frame is accepted.
- R4: Data bits arrive least significant first. The first data bit received ends up in `rx_data[0]`.
- R5: Each bit is decided by majority over samples 8/9/10 (normal) or 4/5/6 (double speed). A single wrong sample in that window does not change the result.
- R6: With `par_en`=1, one parity bit follows the data bits. With `par_odd`=0 the parity bit is expected to equal the XOR of the data bits; with `par_odd`=1 it is expected to equal the inverse of that XOR. A mismatch sets `par_err`. With `par_en`=0 there is no parity bit and `par_err` is 0.
- R7: When the first stop bit votes 0, `frame_err` is 1. Otherwise it is 0.
- R8: `rx_valid` is high for exactly one clock. That clock is the one that follows the tick carrying the last centre sample (10 or 6) of the first stop bit. `rx_data` and both flags are valid on that cycle.
- R9: After the stop-bit decision, a new start is accepted only after a tick has seen the line high. A low line held on from a bad stop bit starts nothing, and extra stop bits are ignored.
- R10: The phase is realigned at every start bit, so frames sent back to back with a single stop bit are each received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_tick | input | 1 | Sample-rate enable, one pulse per line sample |
| dbl_speed | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| par_en | input | 1 | 1: a parity bit follows the data bits |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| rx_data | output | DATA_BITS | Received character |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| par_err | output | 1 | Parity mismatch, valid with the strobe |
| frame_err | output | 1 | First stop bit was low, valid with the strobe |

## Verification
The single result of this block is the strobe with its data and flags. It is due on the clock after tick t0 + (1 + N + P)·S + C, where t0 is the tick that sees the first low slot, N is the number of data bits, P is 1 when parity is on, S is 16 or 8, and C is 9 or 5. The bench changes the line on the falling clock edge right after a tick, and ticks come every four clocks. Because that spacing is longer than the two-flop synchronizer delay, each driven slot is seen by exactly the next tick. The bench counts ticks itself and compares the tick number latched at the strobe against that formula. It reads data and flags only on the strobe cycle and checks for an absence of strobes only after the full window in which one could have appeared.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int PH_W = 5;

    typedef enum logic [2:0] {
        ST_WAIT_HIGH,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } srx_state_e;

    typedef struct packed {
        logic valid;
        logic par_err;
        logic frame_err;
    } srx_flags_t;

    // samples per bit for the selected mode
    function automatic logic [PH_W-1:0] srx_spb(input logic dbl);
        return dbl ? PH_W'(8) : PH_W'(16);
    endfunction

    // middle sample of the three-sample window
    function automatic logic [PH_W-1:0] srx_centre(input logic dbl);
        return dbl ? PH_W'(5) : PH_W'(9);
    endfunction

    function automatic logic srx_maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/srx_phase.sv
module srx_phase
    import srx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic dbl,
    input  logic restart,
    input  logic run,
    output logic in_win,
    output logic decide
);
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] nxt;
    logic [PH_W-1:0] per;
    logic [PH_W-1:0] cen;

    always_comb begin
        per    = srx_spb(dbl);
        cen    = srx_centre(dbl);
        nxt    = (phase >= per) ? PH_W'(1) : phase + PH_W'(1);
        in_win = (nxt == cen - PH_W'(1)) || (nxt == cen) || (nxt == cen + PH_W'(1));
        decide = (nxt == cen + PH_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)              phase <= PH_W'(1);
        else if (restart)     phase <= PH_W'(1);
        else if (run && tick) phase <= nxt;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (phase != '0 && phase <= PH_W'(16))); // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(tick) && !$past(restart)) |-> $stable(phase)); // R2
endmodule

// File: rtl/srx_vote.sv
module srx_vote
    import srx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic take,
    input  logic rx_s,
    output logic bit_val
);
    logic [1:0] held;

    always_ff @(posedge clk) begin
        if (rst)              held <= '0;
        else if (tick && take) held <= {held[0], rx_s};
    end

    assign bit_val = srx_maj3(held[1], held[0], rx_s);
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rx_s,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 decide,
    input  logic                 bit_val,
    output logic                 restart,
    output logic                 run,
    output logic [DATA_BITS-1:0] rx_data,
    output srx_flags_t           flags
);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    srx_state_e           state;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 acc;
    logic                 par_bad;
    logic                 step;

    assign restart = (state == ST_HUNT) && tick && !rx_s;
    assign run     = (state == ST_START) || (state == ST_DATA) ||
                     (state == ST_PARITY) || (state == ST_STOP);
    assign step    = tick && decide;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT_HIGH;
            idx     <= '0;
            shreg   <= '0;
            acc     <= 1'b0;
            par_bad <= 1'b0;
            rx_data <= '0;
            flags   <= '0;
        end else begin
            flags.valid <= 1'b0;
            case (state)
                ST_WAIT_HIGH: if (tick && rx_s) state <= ST_HUNT;
                ST_HUNT:      if (restart) state <= ST_START;
                ST_START: if (step) begin
                    if (bit_val) begin
                        state <= ST_WAIT_HIGH;
                    end else begin
                        state   <= ST_DATA;
                        idx     <= '0;
                        acc     <= 1'b0;
                        par_bad <= 1'b0;
                    end
                end
                ST_DATA: if (step) begin
                    shreg <= {bit_val, shreg[DATA_BITS-1:1]};
                    acc   <= acc ^ bit_val;
                    idx   <= idx + IDX_W'(1);
                    if (idx == LAST_IDX) state <= par_en ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: if (step) begin
                    par_bad <= acc ^ bit_val ^ par_odd;
                    state   <= ST_STOP;
                end
                ST_STOP: if (step) begin
                    rx_data         <= shreg;
                    flags.valid     <= 1'b1;
                    flags.par_err   <= par_en & par_bad;
                    flags.frame_err <= ~bit_val;
                    state           <= ST_WAIT_HIGH;
                end
                default: state <= ST_WAIT_HIGH;
            endcase
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        flags.valid |=> !flags.valid); // R8
    AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        flags.valid |-> $past(tick)); // R8
    AST_STOP_THEN_WAIT: assert property (@(posedge clk) disable iff (rst)
        flags.valid |-> (state == ST_WAIT_HIGH)); // R9
    AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && $past(state) != ST_START) |->
            $past(state == ST_HUNT && !rx_s && tick)); // R3
    AST_NOISE_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_START && state == ST_WAIT_HIGH) |-> !flags.valid); // R3
endmodule

// File: rtl/serial_rx_recover.sv
module serial_rx_recover
    import srx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp_tick,
    input  logic                 dbl_speed,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 par_err,
    output logic                 frame_err
);
    logic       rx_s;
    logic       restart;
    logic       run;
    logic       in_win;
    logic       decide;
    logic       bit_val;
    srx_flags_t flags;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_line),
        .q_sync  (rx_s)
    );

    srx_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick    (samp_tick),
        .dbl     (dbl_speed),
        .restart (restart),
        .run     (run),
        .in_win  (in_win),
        .decide  (decide)
    );

    srx_vote u_vote (
        .clk     (clk),
        .rst     (rst),
        .tick    (samp_tick),
        .take    (in_win && !decide && run),
        .rx_s    (rx_s),
        .bit_val (bit_val)
    );

    srx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick    (samp_tick),
        .rx_s    (rx_s),
        .par_en  (par_en),
        .par_odd (par_odd),
        .decide  (decide),
        .bit_val (bit_val),
        .restart (restart),
        .run     (run),
        .rx_data (rx_data),
        .flags   (flags)
    );

    assign rx_valid  = flags.valid;
    assign par_err   = flags.par_err;
    assign frame_err = flags.frame_err;
endmodule

// File: tb/sim_serial_rx_recover.sv
module sim_serial_rx_recover;
    localparam int DIV = 4;

    typedef struct packed {
        logic [7:0] d;
        logic       dbl;
        logic       pen;
        logic       podd;
        logic       badp;
        logic       stopbad;
    } vec_t;

    localparam vec_t VEC [8] = '{
        {8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hA3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h81, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h7E, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'hC4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h19, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'hF0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       samp_tick = 1'b0;
    logic       dbl_speed = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       par_err;
    logic       frame_err;

    int div_cnt = 0;
    int tick_total = 0;
    int vcount = 0;
    int cap_tick = 0;
    logic [7:0] cap_data = '0;
    logic cap_perr = 1'b0;
    logic cap_ferr = 1'b0;
    int checks = 0;
    int errors = 0;
    int exp_t = 0;
    int v_before = 0;
    int start_glitch = 0;
    int data_glitch = 0;

    always #10 clk = ~clk;

    serial_rx_recover #(.DATA_BITS(8)) u0 (
        .clk       (clk),
        .rst       (rst),
        .samp_tick (samp_tick),
        .dbl_speed (dbl_speed),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .rx_line   (rx_line),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .par_err   (par_err),
        .frame_err (frame_err)
    );

    always @(posedge clk) begin
        if (div_cnt == DIV - 1) begin
            div_cnt   <= 0;
            samp_tick <= 1'b1;
        end else begin
            div_cnt   <= div_cnt + 1;
            samp_tick <= 1'b0;
        end
        if (samp_tick) tick_total <= tick_total + 1;
    end

    always @(posedge clk) begin
        if (rx_valid) begin
            vcount   <= vcount + 1;
            cap_tick <= tick_total;
            cap_data <= rx_data;
            cap_perr <= par_err;
            cap_ferr <= frame_err;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_wait();
        @(posedge clk iff samp_tick);
        @(negedge clk);
    endtask

    task automatic drive_bit(input logic v, input int spb, input int glitch_at);
        for (int s = 1; s <= spb; s++) begin
            rx_line = (s == glitch_at) ? ~v : v;
            tick_wait();
        end
    endtask

    task automatic idle_ticks(input int n);
        rx_line = 1'b1;
        for (int i = 0; i < n; i++) tick_wait();
    endtask

    task automatic send_frame(input logic [7:0] d, input logic dbl, input logic pen,
                              input logic podd, input logic badp, input logic stopbad,
                              input int nstop);
        int spb;
        int cen;
        logic pb;
        spb = dbl ? 8 : 16;
        cen = dbl ? 5 : 9;
        dbl_speed = dbl;
        par_en    = pen;
        par_odd   = podd;
        tick_wait();
        exp_t    = tick_total + 1 + (1 + 8 + int'(pen)) * spb + cen;
        v_before = vcount;
        drive_bit(1'b0, spb, start_glitch);
        for (int i = 0; i < 8; i++) drive_bit(d[i], spb, data_glitch);
        if (pen) begin
            pb = podd ? ~(^d) : (^d);
            drive_bit(pb ^ badp, spb, 0);
        end
        drive_bit(~stopbad, spb, 0);
        for (int i = 1; i < nstop; i++) drive_bit(1'b1, spb, 0);
        rx_line = 1'b1;
    endtask

    task automatic check_frame(input logic [7:0] d, input logic perr, input logic ferr,
                               input string tag);
        chk(vcount == v_before + 1, {tag, " R8 strobe count"}, vcount - v_before, 1);
        chk(cap_data == d, {tag, " R4 data"}, int'(cap_data), int'(d));
        chk(cap_perr == perr, {tag, " R6 parity flag"}, int'(cap_perr), int'(perr));
        chk(cap_ferr == ferr, {tag, " R7 framing flag"}, int'(cap_ferr), int'(ferr));
        chk(cap_tick == exp_t, {tag, " R2 strobe tick"}, cap_tick, exp_t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int vb;
        repeat (3) @(negedge clk);
        chk(!rx_valid && !par_err && !frame_err && rx_data == 8'h00,
            "R1 outputs during reset", int'(rx_valid), 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!rx_valid && !par_err && !frame_err && rx_data == 8'h00,
            "R1 outputs after reset", int'(rx_data), 0);
        idle_ticks(20);

        // table of frames, R2 R4 R6 R7 R8
        for (int k = 0; k < 8; k++) begin
            send_frame(VEC[k].d, VEC[k].dbl, VEC[k].pen, VEC[k].podd,
                       VEC[k].badp, VEC[k].stopbad, 1);
            idle_ticks(4);
            check_frame(VEC[k].d, VEC[k].pen & VEC[k].badp, VEC[k].stopbad, "vec");
            idle_ticks(16);
        end

        // R3: short glitch, normal mode
        dbl_speed = 1'b0;
        vb = vcount;
        tick_wait();
        drive_bit(1'b0, 3, 0);
        idle_ticks(220);
        chk(vcount == vb, "R3 glitch rejected normal", vcount - vb, 0);
        send_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        idle_ticks(4);
        check_frame(8'h96, 1'b0, 1'b0, "R3 after glitch");

        // R3: low through sample 8 only, samples 9 and 10 high -> rejected
        vb = vcount;
        tick_wait();
        drive_bit(1'b0, 8, 0);
        idle_ticks(220);
        chk(vcount == vb, "R3 majority high rejects", vcount - vb, 0);

        // R3: glitch in double speed
        dbl_speed = 1'b1;
        vb = vcount;
        tick_wait();
        drive_bit(1'b0, 2, 0);
        idle_ticks(120);
        chk(vcount == vb, "R3 glitch rejected double", vcount - vb, 0);

        // R3: start sample 10 high but 8 and 9 low -> accepted
        start_glitch = 10;
        send_frame(8'h4B, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1);
        start_glitch = 0;
        idle_ticks(4);
        check_frame(8'h4B, 1'b0, 1'b0, "R3 start majority low");

        // R5: one wrong centre sample in every data bit
        data_glitch = 9;
        send_frame(8'h2D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        idle_ticks(4);
        check_frame(8'h2D, 1'b0, 1'b0, "R5 glitch normal");
        data_glitch = 4;
        send_frame(8'hD2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1);
        idle_ticks(4);
        check_frame(8'hD2, 1'b0, 1'b0, "R5 glitch double");
        data_glitch = 0;

        // R10: back to back, single stop bit
        send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        check_frame(8'h11, 1'b0, 1'b0, "R10 first");
        send_frame(8'hEE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        idle_ticks(4);
        check_frame(8'hEE, 1'b0, 1'b0, "R10 second");

        // R9: two stop bits then immediate next frame
        send_frame(8'h69, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2);
        check_frame(8'h69, 1'b0, 1'b0, "R9 two stops");
        send_frame(8'hA0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        idle_ticks(4);
        check_frame(8'hA0, 1'b0, 1'b0, "R9 after two stops");

        // R9: bad stop bit, line held low afterwards starts nothing
        send_frame(8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1);
        rx_line = 1'b0;
        vb = vcount;
        for (int i = 0; i < 60; i++) tick_wait();
        chk(vb == v_before + 1 && cap_ferr, "R9 bad stop strobe", vb - v_before, 1);
        for (int i = 0; i < 200; i++) tick_wait();
        chk(vcount == vb, "R9 low line starts nothing", vcount - vb, 0);
        idle_ticks(20);
        send_frame(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1);
        idle_ticks(4);
        check_frame(8'h5A, 1'b0, 1'b0, "R9 recovery");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule